// File: doc/BRIEF.md
# Banked File-Register Rotate and Set Executor

This block is one execution slice of an 8-bit accumulator core. It accepts a 16-bit instruction word with a valid strobe and runs two file-register operations against a banked byte memory held inside the block. The first operation rotates a byte one place to the right without using a carry. The second operation fills a byte with all ones. The result of a rotate goes either back to the file location or into the working register. The N and Z flags follow every rotate.

An instruction bit picks how the file address is formed. In one mode a fixed access window is used. In the other mode the bank comes from the bank-select input. The memory holds `NUM_BANKS` banks of 256 bytes. A bank-select value larger than the model wraps modulo the bank count. Reset preloads every location with a value computed from its address. This lets a user see the rotate working on known data without any extra load path.

Each accepted instruction passes through five named states. ST_IDLE moves to ST_DECODE when a recognised word arrives with the strobe. After that the steps run unconditionally: ST_DECODE forms the physical address, ST_READ fetches the operand, ST_PROCESS computes the result and flags, and ST_WRITE commits the result to its destination. ST_WRITE then returns to ST_IDLE. One cycle later the `done` output pulses.

Top module: `fr_rotset_exec`

## Requirements
- R1: A word with bits [15:10] = 6'b010000 is a rotate. Bit 9 is the destination select (1 = file, 0 = working register), bit 8 is the addressing mode, and bits [7:0] are the file address. Such a word is accepted when idle, and `busy` is high on the following cycle.
- R2: A word with bits [15:9] = 7'b0110100 is a set. Bit 8 is the addressing mode and bits [7:0] are the file address. It writes 8'hFF to the addressed byte and leaves the working register unchanged.
- R3: The rotate result is the operand with bit n moved to bit n-1 and bit 0 moved to bit 7, that is {op[0], op[7:1]}.
- R4: For a rotate with destination 0, the result goes to `wreg` and the file byte is unchanged. For a rotate with destination 1, the result replaces the file byte and `wreg` is unchanged.
- R5: After a rotate, `flag_n` equals bit 7 of the result and `flag_z` is 1 exactly when the result is zero. A set leaves both flags unchanged. `wreg` and the flags change only in the cycle that `done` is high.
- R6: With mode bit 0, addresses 0x00–0x7F go to bank 0, addresses 0x80–0xFF go to bank NUM_BANKS-1, and `bsr` is ignored. With mode bit 1, the bank is `bsr` modulo NUM_BANKS, sampled at acceptance.
- R7: `busy` is high for exactly four cycles after the accepting edge. `done` is a single-cycle pulse in the cycle after the write phase, and results are visible on the outputs when `done` is high.
- R8: A word that matches neither pattern is ignored: `busy` stays low and nothing in `wreg`, the flags or memory changes. A strobe raised while `busy` is high is ignored in the same way.
- R9: Reset gives `wreg` = 0, `flag_n` = `flag_z` = 0, `busy` = 0, `done` = 0. It also loads each byte at bank b, offset i with (i*37 + b*101 + 8'h3C) mod 256.
- R10: Rotating a byte holding 8'hD7 gives 8'hEB with N = 1 and Z = 0. With destination 0, the file byte keeps 8'hD7.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| instr_valid | input | 1 | Instruction strobe |
| instr_word | input | 16 | Instruction word |
| bsr | input | BSR_W | Bank-select value |
| wreg | output | 8 | Working register |
| flag_n | output | 1 | Negative flag |
| flag_z | output | 1 | Zero flag |
| busy | output | 1 | Instruction in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
The file memory has no read port at the block's edge. So the hardest effect to observe is the result of a write-back rotate or a set on a byte. The same is true of a strobe that should have been ignored, which must show that it left memory untouched. The stimulus later re-reads the affected byte with a working-register rotate, so every write shows up at `wreg` through a bench memory model. Directed cases find the byte whose preload is 8'hD7 and the byte whose preload is zero. They also place access-window addresses above and below 0x80 under mismatched `bsr` values. Random cases inject extra strobes during `busy` and feed unrecognised words.

// File: rtl/fr_pkg.sv
package fr_pkg;

    localparam int WORD_W = 16;
    localparam int BYTE_W = 8;

    localparam logic [5:0] RRN_PATTERN = 6'b010000;
    localparam logic [6:0] SET_PATTERN = 7'b0110100;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DECODE,
        ST_READ,
        ST_PROCESS,
        ST_WRITE
    } phase_e;

    typedef enum logic [1:0] {
        OP_NONE,
        OP_RRN,
        OP_SET
    } op_e;

    typedef struct packed {
        op_e               op;
        logic              to_file;
        logic              use_bsr;
        logic [BYTE_W-1:0] faddr;
    } instr_s;

    // Reset contents of one memory byte, computed from its bank and offset
    function automatic logic [BYTE_W-1:0] preload_byte(int bank, int offset);
        return BYTE_W'(offset * 37 + bank * 101 + 60);
    endfunction

endpackage

// File: rtl/fr_decode.sv
module fr_decode
    import fr_pkg::*;
(
    input  logic [WORD_W-1:0] instr_word,
    output instr_s            dec
);

    always_comb begin
        dec.op      = OP_NONE;
        dec.to_file = 1'b1;
        dec.use_bsr = instr_word[8];
        dec.faddr   = instr_word[7:0];
        if (instr_word[15:10] == RRN_PATTERN) begin
            dec.op      = OP_RRN;
            dec.to_file = instr_word[9];
        end else if (instr_word[15:9] == SET_PATTERN) begin
            dec.op      = OP_SET;
        end
    end

endmodule

// File: rtl/fr_addr_map.sv
module fr_addr_map
    import fr_pkg::*;
#(
    parameter int NUM_BANKS = 2,
    parameter int BSR_W     = 4,
    localparam int BANK_W   = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
    localparam int PHYS_W   = BANK_W + BYTE_W
)(
    input  logic              use_bsr,
    input  logic [BYTE_W-1:0] faddr,
    input  logic [BSR_W-1:0]  bsr,
    output logic [PHYS_W-1:0] phys
);

    localparam logic [BANK_W-1:0] TOP_BANK = BANK_W'(NUM_BANKS - 1);

    logic [BANK_W-1:0] bank;

    always_comb begin
        if (use_bsr) begin
            bank = BANK_W'(bsr % BSR_W'(NUM_BANKS));
        end else if (faddr[BYTE_W-1]) begin
            bank = TOP_BANK;
        end else begin
            bank = '0;
        end
        phys = {bank, faddr};
    end

endmodule

// File: rtl/fr_alu.sv
module fr_alu
    import fr_pkg::*;
(
    input  op_e               op,
    input  logic [BYTE_W-1:0] operand,
    output logic [BYTE_W-1:0] result,
    output logic              neg,
    output logic              zero
);

    always_comb begin
        unique case (op)
            OP_RRN:  result = {operand[0], operand[BYTE_W-1:1]};
            OP_SET:  result = '1;
            default: result = operand;
        endcase
        neg  = result[BYTE_W-1];
        zero = (result == '0);
    end

endmodule

// File: rtl/fr_regfile.sv
module fr_regfile
    import fr_pkg::*;
#(
    parameter int NUM_BANKS = 2,
    localparam int BANK_W   = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
    localparam int PHYS_W   = BANK_W + BYTE_W,
    localparam int DEPTH    = NUM_BANKS * 256
)(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PHYS_W-1:0] rd_addr,
    output logic [BYTE_W-1:0] rd_data,
    input  logic              wr_en,
    input  logic [PHYS_W-1:0] wr_addr,
    input  logic [BYTE_W-1:0] wr_data
);

    logic [BYTE_W-1:0] mem [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem[i] <= preload_byte(i / 256, i % 256);
            end
        end else if (wr_en) begin
            mem[wr_addr] <= wr_data;
        end
    end

    assign rd_data = mem[rd_addr];

endmodule

// File: rtl/fr_rotset_exec.sv
module fr_rotset_exec
    import fr_pkg::*;
#(
    parameter int NUM_BANKS = 2,
    parameter int BSR_W     = 4,
    localparam int BANK_W   = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
    localparam int PHYS_W   = BANK_W + BYTE_W
)(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              instr_valid,
    input  logic [WORD_W-1:0] instr_word,
    input  logic [BSR_W-1:0]  bsr,
    output logic [BYTE_W-1:0] wreg,
    output logic              flag_n,
    output logic              flag_z,
    output logic              busy,
    output logic              done
);

    phase_e            state, state_nxt;
    instr_s            dec_in, ir;
    logic [BSR_W-1:0]  bsr_q;
    logic [PHYS_W-1:0] phys_comb, phys_q;
    logic [BYTE_W-1:0] rd_data, operand_q;
    logic [BYTE_W-1:0] alu_res, result_q;
    logic              alu_n, alu_z, n_q, z_q;
    logic              accept;

    fr_decode u_dec (
        .instr_word (instr_word),
        .dec        (dec_in)
    );

    fr_addr_map #(.NUM_BANKS(NUM_BANKS), .BSR_W(BSR_W)) u_map (
        .use_bsr (ir.use_bsr),
        .faddr   (ir.faddr),
        .bsr     (bsr_q),
        .phys    (phys_comb)
    );

    fr_alu u_alu (
        .op      (ir.op),
        .operand (operand_q),
        .result  (alu_res),
        .neg     (alu_n),
        .zero    (alu_z)
    );

    fr_regfile #(.NUM_BANKS(NUM_BANKS)) u_rf (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_addr (phys_q),
        .rd_data (rd_data),
        .wr_en   (state == ST_WRITE && ir.to_file),
        .wr_addr (phys_q),
        .wr_data (result_q)
    );

    assign accept = (state == ST_IDLE) && instr_valid && (dec_in.op != OP_NONE);
    assign busy   = (state != ST_IDLE);

    // Phase register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nxt;
        end
    end

    // Phase sequencing
    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_IDLE:    if (accept) state_nxt = ST_DECODE;
            ST_DECODE:  state_nxt = ST_READ;
            ST_READ:    state_nxt = ST_PROCESS;
            ST_PROCESS: state_nxt = ST_WRITE;
            ST_WRITE:   state_nxt = ST_IDLE;
            default:    state_nxt = ST_IDLE;
        endcase
    end

    // Datapath registers advanced by phase
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ir        <= '{op: OP_NONE, to_file: 1'b0, use_bsr: 1'b0, faddr: '0};
            bsr_q     <= '0;
            phys_q    <= '0;
            operand_q <= '0;
            result_q  <= '0;
            n_q       <= 1'b0;
            z_q       <= 1'b0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (accept) begin
                        ir    <= dec_in;
                        bsr_q <= bsr;
                    end
                end
                ST_DECODE:  phys_q    <= phys_comb;
                ST_READ:    operand_q <= rd_data;
                ST_PROCESS: begin
                    result_q <= alu_res;
                    n_q      <= alu_n;
                    z_q      <= alu_z;
                end
                default: ;
            endcase
        end
    end

    // Architectural outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wreg   <= '0;
            flag_n <= 1'b0;
            flag_z <= 1'b0;
            done   <= 1'b0;
        end else begin
            done <= (state == ST_WRITE);
            if (state == ST_WRITE && ir.op == OP_RRN) begin
                flag_n <= n_q;
                flag_z <= z_q;
                if (!ir.to_file) begin
                    wreg <= result_q;
                end
            end
        end
    end

endmodule

// File: rtl/fr_rotset_sva.sv
module fr_rotset_sva
    import fr_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              instr_valid,
    input logic [WORD_W-1:0] instr_word,
    input logic [BYTE_W-1:0] wreg,
    input logic              flag_n,
    input logic              flag_z,
    input logic              busy,
    input logic              done
);

    assert_rrn_accept_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && instr_valid && instr_word[15:10] == 6'b010000) |=> busy);

    assert_set_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && instr_valid && instr_word[15:9] == 7'b0110100) |=> busy);

    assert_wreg_at_done_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(wreg) |-> done);

    assert_flags_at_done_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(flag_n) || !$stable(flag_z)) |-> done);

    assert_latency_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> ##4 done);

    assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_done_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    assert_ignore_unknown_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && instr_valid && instr_word[15:10] != 6'b010000
         && instr_word[15:9] != 7'b0110100) |=> !busy);

endmodule

bind fr_rotset_exec fr_rotset_sva u_sva (
    .clk         (clk),
    .rst_n       (rst_n),
    .instr_valid (instr_valid),
    .instr_word  (instr_word),
    .wreg        (wreg),
    .flag_n      (flag_n),
    .flag_z      (flag_z),
    .busy        (busy),
    .done        (done)
);

// File: tb/sim_fr_rotset_exec.sv
module sim_fr_rotset_exec;

    localparam int NB = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        instr_valid = 1'b0;
    logic [15:0] instr_word = '0;
    logic [3:0]  bsr = '0;
    logic [7:0]  wreg;
    logic        flag_n, flag_z, busy, done;

    int tests = 0;
    int fails = 0;

    logic [7:0] mem_m [NB*256];
    logic [7:0] wreg_m;
    logic       n_m, z_m;

    always #10 clk = ~clk;

    fr_rotset_exec #(.NUM_BANKS(NB), .BSR_W(4)) u0 (
        .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid),
        .instr_word(instr_word), .bsr(bsr), .wreg(wreg),
        .flag_n(flag_n), .flag_z(flag_z), .busy(busy), .done(done)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [7:0] pre(int b, int i);
        return 8'(i * 37 + b * 101 + 60);
    endfunction

    function automatic int phys_of(bit a, logic [7:0] f, logic [3:0] b);
        if (a) return int'(b % NB) * 256 + int'(f);
        return (f >= 8'h80 ? NB - 1 : 0) * 256 + int'(f);
    endfunction

    function automatic bit is_rrn(logic [15:0] w);
        return w[15:10] == 6'b010000;
    endfunction

    function automatic bit is_set(logic [15:0] w);
        return w[15:9] == 7'b0110100;
    endfunction

    function automatic logic [15:0] rrn_w(bit d, bit a, logic [7:0] f);
        return {6'b010000, d, a, f};
    endfunction

    function automatic logic [15:0] set_w(bit a, logic [7:0] f);
        return {7'b0110100, a, f};
    endfunction

    // Issue one word at a negedge, optionally injecting a stray strobe mid-run
    task automatic run(input logic [15:0] w, input logic [3:0] b, input bit stray);
        int cyc;
        bit legal;
        int p;
        logic [7:0] r;
        legal = is_rrn(w) || is_set(w);
        instr_valid = 1'b1; instr_word = w; bsr = b;
        @(negedge clk);
        instr_valid = 1'b0;
        cyc = 1;
        if (!legal) begin
            chk(busy == 1'b0, "R8", "busy after unknown word", busy, 0);
            repeat (2) @(negedge clk);
            chk(busy == 1'b0 && done == 1'b0, "R8", "still idle", {busy, done}, 0);
            chk(wreg == wreg_m, "R8", "wreg untouched", wreg, wreg_m);
            chk({flag_n, flag_z} == {n_m, z_m}, "R8", "flags untouched",
                {flag_n, flag_z}, {n_m, z_m});
            return;
        end
        chk(busy == 1'b1, is_rrn(w) ? "R1" : "R2", "busy after accept", busy, 1);
        while (!done && cyc < 12) begin
            if (stray && cyc == 2) begin
                instr_valid = 1'b1;
                instr_word  = set_w(1'b1, 8'($urandom));
                bsr         = 4'($urandom);
            end else begin
                instr_valid = 1'b0;
            end
            @(negedge clk);
            cyc++;
        end
        instr_valid = 1'b0;
        chk(cyc == 5, "R7", "cycles to done", cyc, 5);
        chk(busy == 1'b0, "R7", "idle at done", busy, 0);
        p = phys_of(w[8], w[7:0], b);
        if (is_rrn(w)) begin
            r = {mem_m[p][0], mem_m[p][7:1]};
            n_m = r[7];
            z_m = (r == 8'h00);
            if (w[9]) mem_m[p] = r;
            else      wreg_m = r;
            chk(wreg == wreg_m, "R3", "wreg after rotate", wreg, wreg_m);
            chk({flag_n, flag_z} == {n_m, z_m}, "R5", "rotate flags",
                {flag_n, flag_z}, {n_m, z_m});
        end else begin
            mem_m[p] = 8'hFF;
            chk(wreg == wreg_m, "R2", "wreg after set", wreg, wreg_m);
            chk({flag_n, flag_z} == {n_m, z_m}, "R5", "set keeps flags",
                {flag_n, flag_z}, {n_m, z_m});
        end
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        tests++; fails++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin : main
        int s;
        int idx_d7, idx_00;
        logic [15:0] w;
        s = $urandom(32'd7151);
        for (int i = 0; i < NB * 256; i++) mem_m[i] = pre(i / 256, i % 256);
        wreg_m = 8'h00; n_m = 1'b0; z_m = 1'b0;
        repeat (3) @(negedge clk);
        chk(wreg == 8'h00 && flag_n == 1'b0 && flag_z == 1'b0, "R9", "reset outputs",
            {wreg, flag_n, flag_z}, 0);
        chk(busy == 1'b0 && done == 1'b0, "R9", "reset handshake", {busy, done}, 0);
        rst_n = 1'b1;
        @(negedge clk);

        idx_d7 = 0; idx_00 = 0;
        for (int i = 0; i < 256; i++) begin
            if (pre(0, i) == 8'hD7) idx_d7 = i;
            if (pre(0, i) == 8'h00) idx_00 = i;
        end

        // R10: working-register destination keeps the file byte
        run(rrn_w(1'b0, 1'b1, 8'(idx_d7)), 4'h0, 1'b0);
        chk(wreg == 8'hEB && flag_n && !flag_z, "R10", "D7 to wreg",
            {wreg, flag_n, flag_z}, {8'hEB, 2'b10});
        // R4 / R10: file destination, then re-read it through wreg
        run(rrn_w(1'b1, 1'b1, 8'(idx_d7)), 4'h2, 1'b0);
        chk(wreg == 8'hEB, "R4", "wreg kept on file write", wreg, 8'hEB);
        run(rrn_w(1'b0, 1'b1, 8'(idx_d7)), 4'h0, 1'b0);
        chk(wreg == 8'hF5, "R4", "file held EB", wreg, 8'hF5);
        // R5: zero result
        run(rrn_w(1'b0, 1'b1, 8'(idx_00)), 4'h4, 1'b0);
        chk(flag_z && !flag_n && wreg == 8'h00, "R5", "zero flag",
            {wreg, flag_n, flag_z}, 1);
        // R6: access window ignores bsr, upper half in top bank
        run(rrn_w(1'b0, 1'b0, 8'h90), 4'h0, 1'b0);
        chk(wreg == {pre(NB-1, 8'h90)[0], pre(NB-1, 8'h90)[7:1]}, "R6",
            "access upper half", wreg, {pre(NB-1, 8'h90)[0], pre(NB-1, 8'h90)[7:1]});
        run(rrn_w(1'b0, 1'b0, 8'h10), 4'h1, 1'b0);
        chk(wreg == {pre(0, 8'h10)[0], pre(0, 8'h10)[7:1]}, "R6",
            "access lower half", wreg, {pre(0, 8'h10)[0], pre(0, 8'h10)[7:1]});
        // R2: set then observe through rotate
        run(set_w(1'b1, 8'h33), 4'h3, 1'b0);
        run(rrn_w(1'b0, 1'b1, 8'h33), 4'h1, 1'b0);
        chk(wreg == 8'hFF && flag_n, "R2", "set wrote FF", wreg, 8'hFF);
        // R8: unknown word and stray strobe while busy
        run(16'hFFFF, 4'h0, 1'b0);
        run(rrn_w(1'b0, 1'b1, 8'h44), 4'h0, 1'b1);

        for (int k = 0; k < 400; k++) begin
            int sel;
            sel = int'($urandom % 20);
            if (sel < 9) begin
                w = rrn_w(1'($urandom), 1'($urandom), 8'($urandom));
            end else if (sel < 16) begin
                w = set_w(1'($urandom), 8'($urandom));
            end else begin
                w = 16'($urandom);
                while (is_rrn(w) || is_set(w)) w = 16'($urandom);
            end
            run(w, 4'($urandom), ($urandom % 4) == 0);
        end

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule